// File: doc/BRIEF.md
# Handshaked FIFO Port Buffer

This block is the buffered port of a broadcast switch. One copy sits on each input of the switch, where it collects words from an attached node and offers them one at a time to the switch scheduler. Another copy sits on each output, where it holds back words headed to a node until that node takes them. Both roles use the same module. The upstream face is a slave and the downstream face is a master. Each face carries three signals: a 3-bit command, a data word and an accept.

Words are stored in a synchronous FIFO. A three-state controller (waiting, fetching, presenting) moves them out. In the fetching state the controller spends one cycle popping the head word into a hold register. In the presenting state it drives that word with a write command until the consumer accepts it. Each word therefore passes through an explicit handshake instead of streaming one word per clock. The upstream face refuses new words while the FIFO is full, so no word is ever dropped.

Top module: `pbuf_port`

## Requirements
- R1: While reset is asserted and after it is released with nothing pushed, `out_cmd` is 3'b000 (idle) and `in_accept` is 1.
- R2: A word is stored only in a cycle where `in_cmd` is 3'b001 (write) and `in_accept` is 1. Any other command code, such as 3'b010 or 3'b111, stores nothing and produces no output.
- R3: `in_accept` is 0 exactly while the FIFO holds DEPTH words. A write offered in that state is not stored.
- R4: When the block is idle and a word is accepted in cycle c, `out_cmd` is 3'b000 in cycles c+1 and c+2. In cycle c+3 it is 3'b001 and `out_data` carries that word.
- R5: While `out_cmd` is 3'b001 and `out_accept` is 0, both `out_cmd` and `out_data` hold their values into the next cycle.
- R6: In the cycle after a word is accepted (`out_cmd` 3'b001 with `out_accept` 1), `out_cmd` is 3'b000. If the FIFO was non-empty in the accepting cycle, the next word appears one cycle after that. Otherwise the block waits until the FIFO is non-empty.
- R7: Words leave in the order they were stored. Every stored word leaves exactly once.
- R8: `out_cmd` only ever takes the values 3'b000 and 3'b001.
- R9: A push and the fetch of the head word may happen in the same cycle, and neither is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_cmd | input | 3 | Upstream command: 3'b000 idle, 3'b001 write |
| in_data | input | WIDTH | Upstream data word |
| in_accept | output | 1 | High when a write offered this cycle is taken |
| out_cmd | output | 3 | Downstream command: 3'b000 idle, 3'b001 write |
| out_data | output | WIDTH | Downstream data word, valid with write |
| out_accept | input | 1 | Consumer takes the presented word this cycle |

## Verification
The bench builds the block with the default 48-bit word and a FIFO depth of 4. That small depth makes the full state, refused writes and the extra slot held in the output register reachable within a few cycles. The same controller and pointer logic serve the deeper 32, 64 and 128 word settings. A behavioural queue model predicts every output each cycle. It is run through the zero-load latency case, illegal command codes, a backpressure fill and a long random phase with stalls on both faces.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam logic [2:0] CMD_IDLE  = 3'b000;
  localparam logic [2:0] CMD_WRITE = 3'b001;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHOW  = 2'd2
  } pbuf_state_e;
endpackage

// File: rtl/pbuf_fifo.sv
module pbuf_fifo #(
  parameter int WIDTH = 48,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
  logic [CW-1:0]    count, count_nx;

  // pointer advance: natural wrap for powers of two, explicit compare otherwise
  generate
    if (POW2) begin : g_wrap_nat
      always_comb begin
        wr_ptr_nx = wr_ptr + AW'(1);
        rd_ptr_nx = rd_ptr + AW'(1);
      end
    end else begin : g_wrap_cmp
      always_comb begin
        wr_ptr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
        rd_ptr_nx = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
    end
  endgenerate

  always_comb begin
    count_nx = count;
    case ({wr_en, rd_en})
      2'b10:   count_nx = count + CW'(1);
      2'b01:   count_nx = count - CW'(1);
      default: count_nx = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr_nx;
      if (rd_en) rd_ptr <= rd_ptr_nx;
      count <= count_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < CW'(DEPTH)));  // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (count != '0));  // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(count));  // R9
endmodule

// File: rtl/pbuf_slave_if.sv
module pbuf_slave_if #(
  parameter int WIDTH = 48
) (
  input  logic [2:0]       in_cmd,
  input  logic [WIDTH-1:0] in_data,
  input  logic             fifo_full,
  output logic             in_accept,
  output logic             push,
  output logic [WIDTH-1:0] push_data
);
  import pbuf_pkg::*;

  always_comb begin
    in_accept = !fifo_full;
    push      = (in_cmd == CMD_WRITE) && !fifo_full;
    push_data = in_data;
  end
endmodule

// File: rtl/pbuf_ctrl.sv
module pbuf_ctrl #(
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_empty,
  input  logic [WIDTH-1:0] head_data,
  input  logic             out_accept,
  output logic             pop,
  output logic [2:0]       out_cmd,
  output logic [WIDTH-1:0] out_data
);
  import pbuf_pkg::*;

  pbuf_state_e      state, state_nx;
  logic [WIDTH-1:0] hold_q;
  logic             hold_en;

  always_comb begin
    state_nx = state;
    case (state)
      ST_WAIT:  if (!fifo_empty) state_nx = ST_FETCH;
      ST_FETCH: state_nx = ST_SHOW;
      ST_SHOW:  if (out_accept) state_nx = fifo_empty ? ST_WAIT : ST_FETCH;
      default:  state_nx = ST_WAIT;
    endcase
  end

  always_comb begin
    pop     = (state == ST_FETCH);
    hold_en = pop;
    out_cmd = (state == ST_SHOW) ? CMD_WRITE : CMD_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_WAIT;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= head_data;
  end

  assign out_data = hold_q;

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cmd == CMD_WRITE && !out_accept) |=> (out_cmd == CMD_WRITE && $stable(out_data)));  // R5
  AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cmd == CMD_WRITE && out_accept) |=> (out_cmd == CMD_IDLE));  // R6
  AST_FETCH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (out_cmd == CMD_WRITE));  // R4
  AST_FETCH_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);  // R7
  AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_cmd) <= 1 && out_cmd[2:1] == 2'b00);  // R8
endmodule

// File: rtl/pbuf_port.sv
module pbuf_port #(
  parameter int WIDTH = 48,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       in_cmd,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_accept,
  output logic [2:0]       out_cmd,
  output logic [WIDTH-1:0] out_data,
  input  logic             out_accept
);
  logic             push, pop, fifo_empty, fifo_full;
  logic [WIDTH-1:0] push_data, head_data;

  pbuf_slave_if #(.WIDTH(WIDTH)) u_slave (
    .in_cmd    (in_cmd),
    .in_data   (in_data),
    .fifo_full (fifo_full),
    .in_accept (in_accept),
    .push      (push),
    .push_data (push_data)
  );

  pbuf_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push),
    .wr_data (push_data),
    .rd_en   (pop),
    .rd_data (head_data),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );

  pbuf_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .head_data  (head_data),
    .out_accept (out_accept),
    .pop        (pop),
    .out_cmd    (out_cmd),
    .out_data   (out_data)
  );

  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd != 3'b001) |-> !push);  // R2
endmodule

// File: tb/pbuf_port_tb.sv
`timescale 1ns/1ps
module pbuf_port_tb;
  localparam int W = 48;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   in_cmd;
  logic [W-1:0] in_data;
  logic         in_accept;
  logic [2:0]   out_cmd;
  logic [W-1:0] out_data;
  logic         out_accept;

  always #2 clk = ~clk;

  pbuf_port #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_cmd(in_cmd), .in_data(in_data), .in_accept(in_accept),
    .out_cmd(out_cmd), .out_data(out_data), .out_accept(out_accept)
  );

  int checks = 0;
  int errors = 0;
  int delivered = 0;
  int overlap = 0;
  bit finished = 0;

  // behavioural model: stored words, presentation phase, presented word
  logic [W-1:0] mq[$];
  logic [W-1:0] order_q[$];
  int           phase = 0;   // 0 waiting, 1 fetching, 2 presenting
  logic [W-1:0] mword = '0;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one cycle: compare outputs, drive inputs, advance model, wait next negedge
  task automatic step(input logic [2:0] cmd, input logic [W-1:0] data, input bit acc);
    int  pre;
    bit  push;
    check(out_cmd == ((phase == 2) ? 3'b001 : 3'b000), "R6 out_cmd", W'(out_cmd), W'((phase == 2) ? 1 : 0));
    if (phase == 2) check(out_data == mword, "R5 out_data", out_data, mword);
    check(in_accept == (mq.size() < D), "R3 in_accept", W'(in_accept), W'(mq.size() < D));
    check(out_cmd == 3'b000 || out_cmd == 3'b001, "R8 out_cmd code", W'(out_cmd), '0);
    in_cmd     = cmd;
    in_data    = data;
    out_accept = acc;
    pre  = mq.size();
    push = (cmd == 3'b001) && (pre < D);
    case (phase)
      0: if (pre > 0) phase = 1;
      1: begin
        mword = mq.pop_front();
        phase = 2;
        if (push) overlap++;
      end
      default: if (acc) begin
        check(order_q.size() > 0 && out_data == order_q[0], "R7 order", out_data,
              (order_q.size() > 0) ? order_q[0] : '0);
        if (order_q.size() > 0) void'(order_q.pop_front());
        delivered++;
        phase = (pre > 0) ? 1 : 0;
      end
    endcase
    if (push) begin
      mq.push_back(data);
      order_q.push_back(data);
    end
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] rword();
    return {$urandom(), $urandom()} & {W{1'b1}};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_cmd = 3'b000; in_data = '0; out_accept = 1'b0;
    repeat (3) @(negedge clk);
    check(out_cmd == 3'b000, "R1 cmd in reset", W'(out_cmd), '0);
    check(in_accept == 1'b1, "R1 accept in reset", W'(in_accept), W'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check(out_cmd == 3'b000, "R1 cmd after reset", W'(out_cmd), '0);

    // R4 zero-load latency
    step(3'b001, 48'hA5A5_0000_0001, 1'b1);
    step(3'b000, '0, 1'b1);
    check(out_cmd == 3'b000, "R4 not before c+3", W'(out_cmd), '0);
    step(3'b000, '0, 1'b1);
    check(out_cmd == 3'b001 && out_data == 48'hA5A5_0000_0001, "R4 latency", out_data, 48'hA5A5_0000_0001);
    for (int i = 0; i < 4; i++) step(3'b000, '0, 1'b1);

    // R2 illegal codes store nothing
    step(3'b010, 48'hDEAD_0000_0002, 1'b1);
    step(3'b111, 48'hDEAD_0000_0003, 1'b1);
    for (int i = 0; i < 4; i++) begin
      check(out_cmd == 3'b000, "R2 nothing stored", W'(out_cmd), '0);
      step(3'b000, '0, 1'b1);
    end
    step(3'b001, 48'h0000_BEEF_0004, 1'b1);
    for (int i = 0; i < 2; i++) step(3'b000, '0, 1'b1);
    check(out_data == 48'h0000_BEEF_0004, "R2 marker first", out_data, 48'h0000_BEEF_0004);
    for (int i = 0; i < 3; i++) step(3'b000, '0, 1'b1);

    // R3 fill under backpressure
    for (int i = 0; i < 6; i++) step(3'b001, W'(48'h1000 + i), 1'b0);
    check(in_accept == 1'b0, "R3 full refuses", W'(in_accept), '0);
    check(out_cmd == 3'b001 && out_data == W'(48'h1000), "R5 held first word", out_data, W'(48'h1000));
    for (int i = 0; i < 20; i++) step(3'b000, '0, 1'b1);
    check(order_q.size() == 0, "R3 refused word absent", W'(order_q.size()), '0);

    // random traffic with stalls on both faces
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] c;
      c = (($urandom() % 5) == 0) ? 3'($urandom()) : ((($urandom() % 2) == 0) ? 3'b001 : 3'b000);
      step(c, rword(), (($urandom() % 3) != 0));
    end
    for (int i = 0; i < 40; i++) step(3'b000, '0, 1'b1);
    check(order_q.size() == 0, "R7 all delivered", W'(order_q.size()), '0);
    check(delivered > 100, "R7 delivery count", W'(delivered), W'(101));
    check(overlap > 0, "R9 push during fetch", W'(overlap), W'(1));
    finish_run();
  end
endmodule